// File: doc/BRIEF.md
# ATA Shadow Status and Interrupt Emulator

This block holds the host-visible copy of the legacy ATA task-file registers and the bus-master status byte for one channel that carries two device slots, slot 0 (master) and slot 1 (slave). Device-side logic reports per-slot completion pulses, error flags and a ready level. The block merges these into the BSY, DRDY and ERR bits that the host reads. It also drives a level interrupt line to the host.

Host software reaches the block over a simple register bus. Writes take effect on the clock edge. Read data is combinational from the address. Writing a command opcode starts a command. For ordinary commands, only the slot chosen by the device-select bit finishes the command. The diagnostics opcode (0x90) is handled differently: it interrupts on the master's completion, and BSY stays set until both slots have reported.

A software reset and the power-up sequence both wait for the two slots, and neither raises an interrupt. Writes to the device-control register are refused until the channel has shown ready once.

Top module: `ata_shadow_irq`

## Requirements
- R1: After reset, the status byte reads 0x80, which is BSY (bit 7) with DRDY (bit 6) taken from the selected slot's ready input. The interrupt line is low, and the bus-master byte (address 9), violation byte (address 10) and error byte (address 1) all read 0x00.
- R2: After reset, BSY stays set until both slots have pulsed completion, in either order. This power-up wait never raises the interrupt.
- R3: A write to device control (address 8) is dropped while the status has never yet shown BSY=0 with DRDY=1. Such a write sets bit 0 of address 10, which holds until the host writes 1 to that bit. The dropped value leaves no trace: nIEN (bit 1) stays clear.
- R4: Writing any opcode to address 7 sets BSY from the next cycle on.
- R5: For a non-diagnostics command, completion comes only from the slot named by bit 4 of address 6 (0 = master, 1 = slave). That slot's completion clears BSY and raises the interrupt in the same cycle. A completion pulse from the other slot has no effect.
- R6: ERR (bit 0 of the status byte) reads 0 while BSY is set. Once BSY clears, ERR shows the error reported by the completing slot. In that state the error byte at address 1 reads 0x04, and it reads 0x00 otherwise.
- R7: For opcode 0x90, the master's completion raises the interrupt at once, whichever slot is selected. If the slave has not finished, BSY stays 1 until the slave also reports. ERR then follows the master's error.
- R8: For opcode 0x90, a slave completion that comes first raises no interrupt. When the master then completes, BSY reads 0 in the same cycle that the interrupt rises. Simultaneous completions behave the same way.
- R9: The bus-master byte sets bit 2 whenever the interrupt is raised. Writing 1 to bit 2 clears that bit and the pending interrupt. Bits 6:5 are read/write, and the other bits read 0. A read, OR 0x04, write-back sequence therefore clears the interrupt and keeps bits 6:5.
- R10: A read of address 7 (status) clears the pending interrupt but leaves bus-master bit 2 set. A read of address 8 (alternate status) returns the same byte and clears nothing.
- R11: nIEN (bit 1 of device control) holds the interrupt line low without clearing the bus-master flag. A request that arrived while masked appears once nIEN is cleared.
- R12: Writing device control with SRST (bit 2) set does the following: it sets BSY, clears the pending interrupt and bus-master bit 2, and keeps BSY set until both slots report completion. No interrupt follows.
- R13: Addresses 2 to 6 read back the last byte written to them. Address 1 accepts writes but reads as the error byte.
- R14: Completion pulses that arrive while no command, reset or power-up wait is outstanding change neither the status byte nor the interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe; read side effects occur at the edge |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from reg_addr |
| dev_done | input | 2 | One-cycle completion pulse per slot (bit 0 master, bit 1 slave) |
| dev_err | input | 2 | Error flag per slot, sampled with dev_done |
| dev_rdy | input | 2 | Ready level per slot, shown as DRDY for the selected slot |
| intrq | output | 1 | Level interrupt to the host |

## Verification
The checker assumes several things about the inputs. The host never issues a read and a write in the same cycle. A completion pulse lasts one cycle. A write to bus-master status is never paired with a read of status in that cycle. Under these assumptions, every fall of the interrupt line can be traced to a host access, and every rise to a slot's completion. The directed stimulus keeps to these rules: all bus activity comes from one-cycle tasks driven on the falling edge, completions are single pulses spaced by host accesses, and each scenario ends by clearing the interrupt through the documented host accesses, so the next scenario starts from a known idle state.

// File: rtl/ata_shadow_pkg.sv
package ata_shadow_pkg;

  localparam int RA_W  = 4;
  localparam int TF_W  = 8;
  localparam int N_DEV = 2;

  // host register addresses
  localparam logic [RA_W-1:0] RA_ERRFEAT = 4'd1;
  localparam logic [RA_W-1:0] RA_STCMD   = 4'd7;
  localparam logic [RA_W-1:0] RA_ALTCTL  = 4'd8;
  localparam logic [RA_W-1:0] RA_BMST    = 4'd9;
  localparam logic [RA_W-1:0] RA_VIOL    = 4'd10;

  // plain read/write task-file bytes occupy this address window
  localparam int TF_LO    = 2;
  localparam int TF_HI    = 6;
  localparam int TF_DEVHD = 6;

  // bit positions
  localparam int ST_BSY    = 7;
  localparam int ST_DRDY   = 6;
  localparam int ST_ERR    = 0;
  localparam int DC_NIEN   = 1;
  localparam int DC_SRST   = 2;
  localparam int DH_DEV    = 4;
  localparam int BM_IRQ    = 2;
  localparam int BM_RW_LSB = 5;
  localparam int BM_RW_W   = 2;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_PWRUP = 3'd1,
    MD_SRST  = 3'd2,
    MD_CMD   = 3'd3,
    MD_DIAG  = 3'd4
  } trk_mode_e;

endpackage

// File: rtl/ata_tf_file.sv
module ata_tf_file
  import ata_shadow_pkg::*;
#(
  parameter int DW = TF_W,
  parameter int AW = RA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          st_bsy,
  input  logic          st_drdy,
  input  logic [DW-1:0] status_byte,
  input  logic [DW-1:0] bm_byte,
  input  logic [DW-1:0] err_byte,
  output logic [DW-1:0] rdata,
  output logic          cmd_wr,
  output logic          st_rd,
  output logic          bm_wr,
  output logic          ctl_wr_ok,
  output logic          dev_sel,
  output logic [DW-1:0] last_opc
);

  logic [DW-1:0]        tf_q [TF_LO:TF_HI];
  logic [TF_HI:TF_LO]   tf_hit;
  logic [DW-1:0]        opc_q, opc_d;
  logic                 pu_ok_q, pu_ok_d;
  logic                 viol_q, viol_d;
  logic                 ready_now, ctl_hit, ctl_allowed, viol_clr;

  generate
    for (genvar r = TF_LO; r <= TF_HI; r++) begin : g_tf_hit
      assign tf_hit[r] = wr_en && (addr == AW'(r));
    end
  endgenerate

  assign cmd_wr      = wr_en && (addr == RA_STCMD);
  assign st_rd       = rd_en && (addr == RA_STCMD);
  assign bm_wr       = wr_en && (addr == RA_BMST);
  assign ctl_hit     = wr_en && (addr == RA_ALTCTL);
  assign viol_clr    = wr_en && (addr == RA_VIOL) && wdata[0];
  assign ready_now   = !st_bsy && st_drdy;
  assign ctl_allowed = pu_ok_q || ready_now;
  assign ctl_wr_ok   = ctl_hit && ctl_allowed;
  assign dev_sel     = tf_q[TF_DEVHD][DH_DEV];
  assign last_opc    = opc_q;

  // next state
  always_comb begin
    opc_d   = cmd_wr ? wdata : opc_q;
    pu_ok_d = pu_ok_q || ready_now;
    viol_d  = viol_q;
    if (ctl_hit && !ctl_allowed) begin
      viol_d = 1'b1;
    end else if (viol_clr) begin
      viol_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = TF_LO; r <= TF_HI; r++) begin
        tf_q[r] <= '0;
      end
      opc_q   <= '0;
      pu_ok_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      for (int r = TF_LO; r <= TF_HI; r++) begin
        if (tf_hit[r]) begin
          tf_q[r] <= wdata;
        end
      end
      if (cmd_wr) begin
        opc_q <= opc_d;
      end
      pu_ok_q <= pu_ok_d;
      viol_q  <= viol_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == RA_ERRFEAT) begin
      rdata = err_byte;
    end else if (addr == RA_STCMD || addr == RA_ALTCTL) begin
      rdata = status_byte;
    end else if (addr == RA_BMST) begin
      rdata = bm_byte;
    end else if (addr == RA_VIOL) begin
      rdata = {{(DW-1){1'b0}}, viol_q};
    end else begin
      for (int r = TF_LO; r <= TF_HI; r++) begin
        if (addr == AW'(r)) begin
          rdata = tf_q[r];
        end
      end
    end
  end

endmodule

// File: rtl/ata_cmpl_track.sv
module ata_cmpl_track
  import ata_shadow_pkg::*;
#(
  parameter int NDEV = N_DEV
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic            cmd_is_diag,
  input  logic            last_is_diag,
  input  logic            srst_evt,
  input  logic            dev_sel,
  input  logic [NDEV-1:0] done_in,
  input  logic [NDEV-1:0] err_in,
  output logic            busy,
  output logic            err_flag,
  output logic            irq_set
);

  trk_mode_e       mode_q, mode_d;
  logic [NDEV-1:0] done_q, done_d;
  logic [NDEV-1:0] err_q, err_d;
  logic [NDEV-1:0] take;
  logic            all_done;
  logic            trk_en;

  // a slot's pulse counts once per outstanding operation; for an
  // ordinary command only the selected slot may count
  generate
    for (genvar g = 0; g < NDEV; g++) begin : g_take
      assign take[g] = done_in[g] && !done_q[g] &&
                       ((mode_q == MD_CMD) ? (g == int'(dev_sel))
                                           : (mode_q != MD_IDLE));
    end
  endgenerate

  assign all_done = &(done_q | take);

  always_comb begin
    done_d  = done_q | take;
    err_d   = err_q | (take & err_in);
    mode_d  = mode_q;
    irq_set = 1'b0;
    unique case (mode_q)
      MD_PWRUP, MD_SRST: begin
        if (all_done) mode_d = MD_IDLE;
      end
      MD_CMD: begin
        if (|take) begin
          irq_set = 1'b1;
          mode_d  = MD_IDLE;
        end
      end
      MD_DIAG: begin
        if (take[0]) irq_set = 1'b1;
        if (all_done) mode_d = MD_IDLE;
      end
      default: ;
    endcase
    if (srst_evt) begin
      done_d  = '0;
      err_d   = '0;
      mode_d  = MD_SRST;
      irq_set = 1'b0;
    end else if (cmd_wr) begin
      done_d  = '0;
      err_d   = '0;
      mode_d  = cmd_is_diag ? MD_DIAG : MD_CMD;
      irq_set = 1'b0;
    end
  end

  assign trk_en = srst_evt || cmd_wr || (|take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_PWRUP;
      done_q <= '0;
      err_q  <= '0;
    end else if (trk_en) begin
      mode_q <= mode_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy     = (mode_q != MD_IDLE);
  assign err_flag = !busy && (last_is_diag ? err_q[0] : err_q[dev_sel]);

endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl
  import ata_shadow_pkg::*;
#(
  parameter int DW = TF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_set,
  input  logic               st_rd,
  input  logic               bm_wr,
  input  logic               bm_w1c,
  input  logic [BM_RW_W-1:0] bm_rw_in,
  input  logic               ctl_wr_ok,
  input  logic               ctl_nien,
  input  logic               srst_evt,
  output logic               intrq,
  output logic               irq_pend,
  output logic               nien,
  output logic [DW-1:0]      bm_byte
);

  logic               pend_q, pend_d;
  logic               flag_q, flag_d;
  logic               nien_q, nien_d;
  logic [BM_RW_W-1:0] rw_q, rw_d;
  logic               bm_clr;

  assign bm_clr = bm_wr && bm_w1c;

  always_comb begin
    pend_d = pend_q;
    flag_d = flag_q;
    if (srst_evt) begin
      pend_d = 1'b0;
      flag_d = 1'b0;
    end else if (irq_set) begin
      pend_d = 1'b1;
      flag_d = 1'b1;
    end else begin
      if (st_rd || bm_clr) pend_d = 1'b0;
      if (bm_clr)          flag_d = 1'b0;
    end
    nien_d = ctl_wr_ok ? ctl_nien : nien_q;
    rw_d   = bm_wr ? bm_rw_in : rw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
      nien_q <= 1'b0;
      rw_q   <= '0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
      if (ctl_wr_ok) nien_q <= nien_d;
      if (bm_wr)     rw_q   <= rw_d;
    end
  end

  always_comb begin
    bm_byte                          = '0;
    bm_byte[BM_IRQ]                  = flag_q;
    bm_byte[BM_RW_LSB +: BM_RW_W]    = rw_q;
  end

  assign irq_pend = pend_q;
  assign nien     = nien_q;
  assign intrq    = pend_q && !nien_q;

endmodule

// File: rtl/ata_shadow_irq.sv
module ata_shadow_irq
  import ata_shadow_pkg::*;
#(
  parameter int            DW        = TF_W,
  parameter int            AW        = RA_W,
  parameter int            NDEV      = N_DEV,
  parameter logic [DW-1:0] DIAG_OPC  = 8'h90,
  parameter logic [DW-1:0] ABRT_CODE = 8'h04
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NDEV-1:0] dev_done,
  input  logic [NDEV-1:0] dev_err,
  input  logic [NDEV-1:0] dev_rdy,
  output logic            intrq
);

  logic [1:0]    rst_pipe_q;
  logic          rst_n_s;
  logic          busy, err_flag, drdy;
  logic          irq_set, irq_pend, nien;
  logic          cmd_wr, st_rd, bm_wr, ctl_wr_ok, srst_evt;
  logic          dev_sel, cmd_is_diag, last_is_diag;
  logic [DW-1:0] last_opc, status_byte, err_byte, bm_byte;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  assign drdy         = dev_rdy[dev_sel];
  assign cmd_is_diag  = (reg_wdata == DIAG_OPC);
  assign last_is_diag = (last_opc == DIAG_OPC);
  assign srst_evt     = ctl_wr_ok && reg_wdata[DC_SRST];
  assign err_byte     = err_flag ? ABRT_CODE : '0;

  always_comb begin
    status_byte          = '0;
    status_byte[ST_BSY]  = busy;
    status_byte[ST_DRDY] = drdy;
    status_byte[ST_ERR]  = err_flag;
  end

  ata_tf_file #(.DW(DW), .AW(AW)) u_tf (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (reg_wr),
    .rd_en       (reg_rd),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .st_bsy      (busy),
    .st_drdy     (drdy),
    .status_byte (status_byte),
    .bm_byte     (bm_byte),
    .err_byte    (err_byte),
    .rdata       (reg_rdata),
    .cmd_wr      (cmd_wr),
    .st_rd       (st_rd),
    .bm_wr       (bm_wr),
    .ctl_wr_ok   (ctl_wr_ok),
    .dev_sel     (dev_sel),
    .last_opc    (last_opc)
  );

  ata_cmpl_track #(.NDEV(NDEV)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cmd_wr       (cmd_wr),
    .cmd_is_diag  (cmd_is_diag),
    .last_is_diag (last_is_diag),
    .srst_evt     (srst_evt),
    .dev_sel      (dev_sel),
    .done_in      (dev_done),
    .err_in       (dev_err),
    .busy         (busy),
    .err_flag     (err_flag),
    .irq_set      (irq_set)
  );

  ata_irq_ctl #(.DW(DW)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .irq_set   (irq_set),
    .st_rd     (st_rd),
    .bm_wr     (bm_wr),
    .bm_w1c    (reg_wdata[BM_IRQ]),
    .bm_rw_in  (reg_wdata[BM_RW_LSB +: BM_RW_W]),
    .ctl_wr_ok (ctl_wr_ok),
    .ctl_nien  (reg_wdata[DC_NIEN]),
    .srst_evt  (srst_evt),
    .intrq     (intrq),
    .irq_pend  (irq_pend),
    .nien      (nien),
    .bm_byte   (bm_byte)
  );

endmodule

// File: rtl/ata_shadow_irq_chk.sv
module ata_shadow_irq_chk
  import ata_shadow_pkg::*;
#(
  parameter int DW   = TF_W,
  parameter int AW   = RA_W,
  parameter int NDEV = N_DEV
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [AW-1:0]   reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [NDEV-1:0] dev_done,
  input logic            busy,
  input logic            irq_set,
  input logic            irq_pend,
  input logic            srst_evt,
  input logic            ctl_wr_ok,
  input logic            nien,
  input logic            intrq,
  input logic [DW-1:0]   bm_byte
);

  assert_cmd_sets_bsy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_STCMD) |=> busy);

  assert_irq_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(|dev_done));

  assert_bm_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_BMST && reg_wdata[BM_IRQ] && !irq_set) |=> !bm_byte[BM_IRQ]);

  assert_alt_rd_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && reg_addr == RA_ALTCTL && irq_pend) |=> irq_pend);

  assert_intr_fall_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intrq) |-> $past(reg_rd || reg_wr));

  assert_nien_keeps_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_ok && reg_wdata[DC_NIEN] && !srst_evt && bm_byte[BM_IRQ]) |=> bm_byte[BM_IRQ]);

  assert_nien_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (nien && $stable(nien)) |-> !intrq);

  assert_srst_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    srst_evt |=> (busy && !irq_pend));

endmodule

bind ata_shadow_irq ata_shadow_irq_chk #(.DW(DW), .AW(AW), .NDEV(NDEV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .dev_done  (dev_done),
  .busy      (busy),
  .irq_set   (irq_set),
  .irq_pend  (irq_pend),
  .srst_evt  (srst_evt),
  .ctl_wr_ok (ctl_wr_ok),
  .nien      (nien),
  .intrq     (intrq),
  .bm_byte   (bm_byte)
);

// File: tb/ata_shadow_irq_tb_top.sv
module ata_shadow_irq_tb_top;

  logic       clk;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [1:0] dev_done, dev_err, dev_rdy;
  logic       intrq;

  int n_chk;
  int n_fail;
  bit finished;

  localparam logic [3:0] A_ERR = 4'd1, A_ST = 4'd7, A_ALT = 4'd8, A_BM = 4'd9, A_VIO = 4'd10, A_DH = 4'd6;

  ata_shadow_irq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dev_done  (dev_done),
    .dev_err   (dev_err),
    .dev_rdy   (dev_rdy),
    .intrq     (intrq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] m, input logic [1:0] e);
    dev_done = m; dev_err = e;
    @(negedge clk);
    dev_done = '0; dev_err = '0;
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic chk_intr(input string req, input logic exp);
    check(req, {7'b0, intrq}, {7'b0, exp});
  endtask

  task automatic clear_irq();
    logic [7:0] v;
    bus_rd(A_ST, v);
    bus_rd(A_BM, v);
    bus_wr(A_BM, v | 8'h04);
  endtask

  task automatic t_reset();
    chk_rd("R1 status", A_ALT, 8'h80);
    chk_intr("R1 intrq", 1'b0);
    chk_rd("R1 bm", A_BM, 8'h00);
    chk_rd("R1 viol", A_VIO, 8'h00);
    chk_rd("R1 err", A_ERR, 8'h00);
  endtask

  task automatic t_powerup();
    bus_wr(A_ALT, 8'h02);
    chk_rd("R3 viol set", A_VIO, 8'h01);
    chk_rd("R3 status unchanged", A_ALT, 8'h80);
    dev_rdy = 2'b11;
    @(negedge clk);
    chk_rd("R2 waiting", A_ALT, 8'hC0);
    pulse(2'b01, 2'b00);
    chk_rd("R2 one slot", A_ALT, 8'hC0);
    pulse(2'b10, 2'b00);
    chk_rd("R2 both slots", A_ALT, 8'h40);
    chk_intr("R2 no intr", 1'b0);
    chk_rd("R3 viol sticky", A_VIO, 8'h01);
    bus_wr(A_VIO, 8'h01);
    chk_rd("R3 viol cleared", A_VIO, 8'h00);
  endtask

  task automatic t_taskfile();
    for (int k = 2; k <= 5; k++) bus_wr(4'(k), 8'(k * 17));
    bus_wr(A_DH, 8'hA0);
    for (int k = 2; k <= 5; k++) chk_rd("R13 readback", 4'(k), 8'(k * 17));
    chk_rd("R13 devhd", A_DH, 8'hA0);
    bus_wr(A_ERR, 8'h55);
    chk_rd("R13 feat write hidden", A_ERR, 8'h00);
  endtask

  task automatic t_plain();
    bus_wr(A_ST, 8'hEC);
    chk_rd("R4 bsy set", A_ALT, 8'hC0);
    chk_intr("R4 no intr yet", 1'b0);
    pulse(2'b10, 2'b10);
    chk_rd("R5 other slot ignored", A_ALT, 8'hC0);
    chk_intr("R5 other slot no intr", 1'b0);
    pulse(2'b01, 2'b01);
    chk_intr("R5 selected done intr; R3 nIEN write dropped", 1'b1);
    chk_rd("R6 err shown", A_ALT, 8'h41);
    chk_rd("R6 error byte", A_ERR, 8'h04);
    chk_intr("R10 alt read keeps", 1'b1);
    chk_rd("R10 status read", A_ST, 8'h41);
    chk_intr("R10 status read clears", 1'b0);
    chk_rd("R10 bm flag kept", A_BM, 8'h04);
    bus_wr(A_BM, 8'h04);
    chk_rd("R9 w1c", A_BM, 8'h00);
  endtask

  task automatic t_slave_sel();
    bus_wr(A_DH, 8'hB0);
    bus_wr(A_ST, 8'h20);
    chk_rd("R4 bsy set slave", A_ALT, 8'hC0);
    pulse(2'b01, 2'b00);
    chk_rd("R5 master ignored", A_ALT, 8'hC0);
    chk_intr("R5 master no intr", 1'b0);
    pulse(2'b10, 2'b00);
    chk_intr("R5 slave intr", 1'b1);
    chk_rd("R5 slave done", A_ALT, 8'h40);
    clear_irq();
  endtask

  task automatic t_diag_master_first();
    bus_wr(A_ST, 8'h90);
    pulse(2'b01, 2'b01);
    chk_intr("R7 master intr", 1'b1);
    chk_rd("R7 bsy held, err hidden", A_ALT, 8'hC0);
    pulse(2'b10, 2'b00);
    chk_rd("R7 slave frees bsy", A_ALT, 8'h41);
    chk_intr("R7 intr stays", 1'b1);
    clear_irq();
  endtask

  task automatic t_diag_slave_first();
    bus_wr(A_ST, 8'h90);
    pulse(2'b10, 2'b10);
    chk_intr("R8 slave no intr", 1'b0);
    chk_rd("R8 still busy", A_ALT, 8'hC0);
    pulse(2'b01, 2'b00);
    chk_intr("R8 master intr", 1'b1);
    chk_rd("R8 bsy clear with intr", A_ALT, 8'h40);
    clear_irq();
    bus_wr(A_ST, 8'h90);
    pulse(2'b11, 2'b00);
    chk_intr("R8 simultaneous intr", 1'b1);
    chk_rd("R8 simultaneous bsy", A_ALT, 8'h40);
    clear_irq();
  endtask

  task automatic t_bm();
    logic [7:0] v;
    bus_wr(A_BM, 8'h60);
    chk_rd("R9 rw bits", A_BM, 8'h60);
    bus_wr(A_ST, 8'hEC);
    pulse(2'b10, 2'b00);
    chk_rd("R9 flag set", A_BM, 8'h64);
    bus_rd(A_BM, v);
    bus_wr(A_BM, v | 8'h04);
    chk_rd("R9 rmw keeps rw bits", A_BM, 8'h60);
    chk_intr("R9 rmw clears intr", 1'b0);
  endtask

  task automatic t_nien();
    bus_wr(A_ALT, 8'h02);
    bus_wr(A_ST, 8'hEC);
    pulse(2'b10, 2'b00);
    chk_intr("R11 masked", 1'b0);
    chk_rd("R11 flag still set", A_BM, 8'h64);
    bus_wr(A_ALT, 8'h00);
    chk_intr("R11 unmasked pending", 1'b1);
    bus_wr(A_BM, 8'h64);
    chk_intr("R11 cleared", 1'b0);
  endtask

  task automatic t_srst();
    bus_wr(A_ST, 8'hEC);
    pulse(2'b10, 2'b00);
    chk_intr("R12 pending before", 1'b1);
    bus_wr(A_ALT, 8'h04);
    chk_rd("R12 bsy", A_ALT, 8'hC0);
    chk_intr("R12 intr cleared", 1'b0);
    chk_rd("R12 flag cleared", A_BM, 8'h60);
    bus_wr(A_ALT, 8'h00);
    pulse(2'b01, 2'b00);
    chk_rd("R12 waits for both", A_ALT, 8'hC0);
    pulse(2'b10, 2'b00);
    chk_rd("R12 done", A_ALT, 8'h40);
    chk_intr("R12 no intr", 1'b0);
  endtask

  task automatic t_idle();
    pulse(2'b11, 2'b11);
    chk_rd("R14 status unchanged", A_ALT, 8'h40);
    chk_intr("R14 no intr", 1'b0);
    chk_rd("R14 bm unchanged", A_BM, 8'h60);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    dev_done = '0; dev_err = '0; dev_rdy = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_powerup();
    t_taskfile();
    t_plain();
    t_slave_sel();
    t_diag_master_first();
    t_diag_slave_first();
    t_bm();
    t_nien();
    t_srst();
    t_idle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule